// File: doc/BRIEF.md
# Signature-Driven Stride Predictor

This block learns irregular but repeating stride sequences per program counter and turns them into prefetch addresses. The caller owns the per-PC tracking. For each memory access it hands over the PC's current history signature, the cache-line address that was touched and the stride just observed for that PC. The block trains a shared table entry that is indexed by the old signature, so that the entry learns "after this history, this stride came next". It returns the new signature for the caller to store back, and then follows the table from the new signature to emit up to three prefetch line addresses.

The signature is a 12-bit hash of recent strides. The table holds one 9-bit entry per signature value: a 7-bit two's-complement stride and a 2-bit saturating confidence. The prediction walk adds each predicted stride to a running line address. It advances the signature speculatively with the same hash, so one trained history can yield a chain of different strides (for example +1, +2, +3, -3).

Control is a four-state machine. The states are `ST_CLEAR`, `ST_IDLE`, `ST_TRAIN` and `ST_WALK`, with these transitions:

- **clear-done**: `ST_CLEAR` to `ST_IDLE` after the last entry is zeroed.
- **accept**: `ST_IDLE` to `ST_TRAIN` when `req_valid` is high.
- **train-done**: `ST_TRAIN` to `ST_WALK`, unconditional.
- **walk-stop**: `ST_WALK` to `ST_IDLE` when confidence is zero, when the page would be crossed, or when the third prefetch has been issued.
- **walk-step**: `ST_WALK` to `ST_WALK` otherwise.

Top module: `sig_stride_pred`

## Requirements
- R1: After reset the block zeroes all 2^SIG_W table entries, one per cycle, in `ST_CLEAR`. During that sweep `ready`, `sig_valid` and `pf_valid` stay low. `ready` first reads high at the falling edge after the 2^SIG_W-th rising clock edge following reset release.
- R2: A request is taken only on a rising edge where `ready` and `req_valid` are both high. `req_valid` asserted while `ready` is low has no effect on any output or on the table.
- R3: One cycle after acceptance, `sig_valid` pulses for exactly one cycle. At the same time `sig_out` equals `((req_sig << 1) XOR req_stride_bits)` kept to the low 12 bits, where the 7 stride bits are zero-extended.
- R4: If the entry at the old signature already holds the observed stride, its confidence rises by one and saturates at 3. Repeated identical histories therefore lead to full three-prefetch chains.
- R5: If the entry at the old signature holds a different stride, its confidence falls by one, not below 0. When the result is 0, the stride field is overwritten with the observed stride.
- R6: Training is written before the walk starts, so the walk sees it. Starting one cycle after `sig_valid`, each cycle of the walk reads the entry at the running signature. It issues `pf_line` = running line + sign-extended stride, then advances both the line and the signature by the R3 hash.
- R7: The walk ends without a prefetch when the entry it reads has confidence 0.
- R8: The walk ends without a prefetch when the next line would lie in a different 64-line page. Page = line address bits above bit 5.
- R9: At most 3 prefetches are issued per request, on consecutive cycles. `ready` returns high in the cycle the walk ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request present |
| req_sig | input | 12 | Signature stored for the PC before this access |
| req_line | input | 26 | Cache-line address of the access |
| req_stride | input | 7 | Observed stride, two's complement |
| ready | output | 1 | Block idle and able to accept a request |
| sig_valid | output | 1 | One-cycle strobe for `sig_out` |
| sig_out | output | 12 | Updated signature to store back for the PC |
| pf_valid | output | 1 | Prefetch address valid this cycle |
| pf_line | output | 26 | Prefetch cache-line address |

## Verification
The assertions assume the caller never raises `req_valid` during reset. They also assume line addresses stay far enough from the ends of the address space that a stride cannot wrap around. The bench keeps every line in mid-range pages and checks the wrap-free arithmetic against a behavioural table model. The assertions accept `req_valid` at any time, including while busy. The stimulus uses this by driving a stray request during training, so that the ignore rule is exercised rather than assumed.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
    localparam int STRIDE_W = 7;
    localparam int CONF_W   = 2;
    localparam int ENT_W    = STRIDE_W + CONF_W;

    typedef enum logic [1:0] {
        ST_CLEAR,
        ST_IDLE,
        ST_TRAIN,
        ST_WALK
    } ssp_state_e;
endpackage

// File: rtl/ssp_store.sv
module ssp_store #(
    parameter int SIG_W = 12,
    parameter int ENT_W = 9
) (
    input  logic             clk,
    input  logic             we,
    input  logic [SIG_W-1:0] waddr,
    input  logic [ENT_W-1:0] wdata,
    input  logic [SIG_W-1:0] raddr,
    output logic [ENT_W-1:0] rdata
);
    localparam int DEPTH = 1 << SIG_W;

    logic [ENT_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/ssp_train.sv
module ssp_train
    import ssp_pkg::*;
(
    input  logic [STRIDE_W-1:0] old_stride,
    input  logic [CONF_W-1:0]   old_conf,
    input  logic [STRIDE_W-1:0] obs_stride,
    output logic [STRIDE_W-1:0] new_stride,
    output logic [CONF_W-1:0]   new_conf
);
    localparam logic [CONF_W-1:0] CONF_MAX = '1;

    logic              hit;
    logic [CONF_W-1:0] conf_dn;

    always_comb begin
        hit     = (old_stride == obs_stride);
        conf_dn = (old_conf == '0) ? '0 : old_conf - CONF_W'(1);
        if (hit) begin
            new_conf   = (old_conf == CONF_MAX) ? old_conf : old_conf + CONF_W'(1);
            new_stride = old_stride;
        end else begin
            new_conf   = conf_dn;
            new_stride = (conf_dn == '0) ? obs_stride : old_stride;
        end
    end

    // R4 / R5: confidence moves by at most one step per training event
    always_comb begin
        if (hit) begin
            a_up_r4: assert (new_conf >= old_conf);
        end else begin
            a_down_r5: assert (new_conf <= old_conf);
        end
    end
endmodule

// File: rtl/ssp_step.sv
module ssp_step
    import ssp_pkg::*;
#(
    parameter int LINE_W    = 26,
    parameter int PAGE_LOG2 = 6
) (
    input  logic [LINE_W-1:0]   cur_line,
    input  logic [STRIDE_W-1:0] ent_stride,
    input  logic [CONF_W-1:0]   ent_conf,
    output logic [LINE_W-1:0]   nxt_line,
    output logic                go
);
    logic same_page;

    always_comb begin
        nxt_line  = cur_line + {{(LINE_W-STRIDE_W){ent_stride[STRIDE_W-1]}}, ent_stride};
        same_page = (nxt_line[LINE_W-1:PAGE_LOG2] == cur_line[LINE_W-1:PAGE_LOG2]);
        go        = (ent_conf != '0) && same_page;
    end
endmodule

// File: rtl/sig_stride_pred.sv
module sig_stride_pred
    import ssp_pkg::*;
#(
    parameter int SIG_W     = 12,
    parameter int LINE_W    = 26,
    parameter int PAGE_LOG2 = 6,
    parameter int MAX_PF    = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [SIG_W-1:0]    req_sig,
    input  logic [LINE_W-1:0]   req_line,
    input  logic [STRIDE_W-1:0] req_stride,
    output logic                ready,
    output logic                sig_valid,
    output logic [SIG_W-1:0]    sig_out,
    output logic                pf_valid,
    output logic [LINE_W-1:0]   pf_line
);
    localparam int CNT_W = $clog2(MAX_PF + 1);
    localparam logic [CNT_W-1:0] LAST_PF = CNT_W'(MAX_PF - 1);

    function automatic logic [SIG_W-1:0] sig_hash(input logic [SIG_W-1:0] s,
                                                 input logic [STRIDE_W-1:0] d);
        return {s[SIG_W-2:0], 1'b0} ^ {{(SIG_W-STRIDE_W){1'b0}}, d};
    endfunction

    ssp_state_e          state_q, state_d;
    logic [SIG_W-1:0]    clr_idx_q;
    logic [SIG_W-1:0]    sig_q;
    logic [LINE_W-1:0]   line_q;
    logic [STRIDE_W-1:0] stride_q;
    logic [SIG_W-1:0]    walk_sig_q;
    logic [LINE_W-1:0]   walk_line_q;
    logic [CNT_W-1:0]    walk_cnt_q;

    logic                sig_valid_q, pf_valid_q;
    logic [SIG_W-1:0]    sig_out_q;
    logic [LINE_W-1:0]   pf_line_q;

    logic [ENT_W-1:0]    rd_ent, wr_ent;
    logic [SIG_W-1:0]    rd_idx, wr_idx;
    logic                wr_en;
    logic [STRIDE_W-1:0] tr_stride;
    logic [CONF_W-1:0]   tr_conf;
    logic [LINE_W-1:0]   nxt_line;
    logic                step_go;
    logic [SIG_W-1:0]    sig_new;

    // table ports
    always_comb begin
        rd_idx = (state_q == ST_TRAIN) ? sig_q : walk_sig_q;
        wr_en  = (state_q == ST_CLEAR) || (state_q == ST_TRAIN);
        wr_idx = (state_q == ST_CLEAR) ? clr_idx_q : sig_q;
        wr_ent = (state_q == ST_CLEAR) ? '0 : {tr_stride, tr_conf};
        sig_new = sig_hash(sig_q, stride_q);
    end

    ssp_store #(.SIG_W(SIG_W), .ENT_W(ENT_W)) i_store (
        .clk   (clk),
        .we    (wr_en),
        .waddr (wr_idx),
        .wdata (wr_ent),
        .raddr (rd_idx),
        .rdata (rd_ent)
    );

    ssp_train i_train (
        .old_stride (rd_ent[ENT_W-1:CONF_W]),
        .old_conf   (rd_ent[CONF_W-1:0]),
        .obs_stride (stride_q),
        .new_stride (tr_stride),
        .new_conf   (tr_conf)
    );

    ssp_step #(.LINE_W(LINE_W), .PAGE_LOG2(PAGE_LOG2)) i_step (
        .cur_line   (walk_line_q),
        .ent_stride (rd_ent[ENT_W-1:CONF_W]),
        .ent_conf   (rd_ent[CONF_W-1:0]),
        .nxt_line   (nxt_line),
        .go         (step_go)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLEAR: if (clr_idx_q == '1) state_d = ST_IDLE;
            ST_IDLE:  if (req_valid)       state_d = ST_TRAIN;
            ST_TRAIN:                      state_d = ST_WALK;
            ST_WALK:  if (!step_go || walk_cnt_q == LAST_PF) state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_CLEAR;
        else        state_q <= state_d;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clr_idx_q   <= '0;
            sig_q       <= '0;
            line_q      <= '0;
            stride_q    <= '0;
            walk_sig_q  <= '0;
            walk_line_q <= '0;
            walk_cnt_q  <= '0;
            sig_valid_q <= 1'b0;
            sig_out_q   <= '0;
            pf_valid_q  <= 1'b0;
            pf_line_q   <= '0;
        end else begin
            sig_valid_q <= 1'b0;
            pf_valid_q  <= 1'b0;
            unique case (state_q)
                ST_CLEAR: clr_idx_q <= clr_idx_q + SIG_W'(1);
                ST_IDLE: begin
                    if (req_valid) begin
                        sig_q    <= req_sig;
                        line_q   <= req_line;
                        stride_q <= req_stride;
                    end
                end
                ST_TRAIN: begin
                    sig_valid_q <= 1'b1;
                    sig_out_q   <= sig_new;
                    walk_sig_q  <= sig_new;
                    walk_line_q <= line_q;
                    walk_cnt_q  <= '0;
                end
                ST_WALK: begin
                    if (step_go) begin
                        pf_valid_q  <= 1'b1;
                        pf_line_q   <= nxt_line;
                        walk_line_q <= nxt_line;
                        walk_sig_q  <= sig_hash(walk_sig_q, rd_ent[ENT_W-1:CONF_W]);
                        walk_cnt_q  <= walk_cnt_q + CNT_W'(1);
                    end
                end
            endcase
        end
    end

    assign ready     = (state_q == ST_IDLE);
    assign sig_valid = sig_valid_q;
    assign sig_out   = sig_out_q;
    assign pf_valid  = pf_valid_q;
    assign pf_line   = pf_line_q;

    p_quiet_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CLEAR) |-> (!pf_valid && !sig_valid));

    p_busy_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> ($stable(line_q) && $stable(stride_q)));

    p_sig_after_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && req_valid) |=> ##1 sig_valid);

    p_sig_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sig_valid |=> !sig_valid);

    p_pf_from_walk_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> ($past(state_q) == ST_WALK));

    p_same_page_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_valid && $past(pf_valid)) |->
            (pf_line[LINE_W-1:PAGE_LOG2] == $past(pf_line[LINE_W-1:PAGE_LOG2])));

    p_walk_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WALK) |-> (walk_cnt_q <= LAST_PF));
endmodule

// File: tb/test_sig_stride_pred.sv
module test_sig_stride_pred;
    localparam int CLK_PERIOD = 10;
    localparam int SIG_W  = 12;
    localparam int LINE_W = 26;
    localparam int DEPTH  = 1 << SIG_W;
    localparam int WDOG   = 150000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [SIG_W-1:0]  req_sig = '0;
    logic [LINE_W-1:0] req_line = '0;
    logic [6:0]        req_stride = '0;
    logic              ready, sig_valid, pf_valid;
    logic [SIG_W-1:0]  sig_out;
    logic [LINE_W-1:0] pf_line;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;
    int m_str [DEPTH];
    int m_conf [DEPTH];

    sig_stride_pred i_sig_stride_pred (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sig(req_sig),
        .req_line(req_line), .req_stride(req_stride), .ready(ready),
        .sig_valid(sig_valid), .sig_out(sig_out), .pf_valid(pf_valid), .pf_line(pf_line)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic end_test;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == WDOG) begin
            n_fail++;
            $display("FAIL watchdog (all requirements): cycles %0d expected below %0d", cycles, WDOG);
            end_test;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
        end
    endtask

    function automatic int hsh(input int s, input int d);
        return ((s << 1) ^ (d & 127)) & (DEPTH - 1);
    endfunction

    // Entered and left at a falling edge with ready high.
    task automatic do_req(input int sig, input int line, input int s, input bit poke,
                          input string tag, output int new_sig, output int n_pf);
        int exp_l [3];
        int n = 0;
        string stop_tag = "R9";
        int ws, wa;
        // model: train the old signature
        if (m_str[sig] == s) begin
            if (m_conf[sig] < 3) m_conf[sig]++;
        end else begin
            if (m_conf[sig] > 0) m_conf[sig]--;
            if (m_conf[sig] == 0) m_str[sig] = s;
        end
        new_sig = hsh(sig, s);
        ws = new_sig;
        wa = line;
        for (int i = 0; i < 3; i++) begin
            if (m_conf[ws] == 0) begin stop_tag = "R7"; break; end
            if (((wa + m_str[ws]) >> 6) != (wa >> 6)) begin stop_tag = "R8"; break; end
            wa = wa + m_str[ws];
            exp_l[n] = wa;
            n++;
            ws = hsh(ws, m_str[ws]);
        end
        // drive
        req_valid  = 1'b1;
        req_sig    = SIG_W'(sig);
        req_line   = LINE_W'(line);
        req_stride = 7'(s);
        @(negedge clk);
        if (poke) begin
            req_sig = ~req_sig; req_line = req_line + 26'd9; req_stride = 7'd33;
        end else begin
            req_valid = 1'b0;
        end
        chk(ready == 1'b0, "R2", int'(ready), 0);
        @(negedge clk);
        req_valid = 1'b0;
        chk(sig_valid == 1'b1, poke ? "R2" : "R3", int'(sig_valid), 1);
        chk(int'(sig_out) == new_sig, poke ? "R2" : "R3", int'(sig_out), new_sig);
        n_pf = 0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            if (i < n) begin
                chk(pf_valid == 1'b1, tag, int'(pf_valid), 1);
                chk(int'(pf_line) == exp_l[i], tag, int'(pf_line), exp_l[i]);
                if (pf_valid) n_pf++;
                chk(ready == (i == 2), "R9", int'(ready), int'(i == 2));
            end else begin
                chk(pf_valid == 1'b0, stop_tag, int'(pf_valid), 0);
                chk(ready == 1'b1, stop_tag, int'(ready), 1);
                break;
            end
        end
    endtask

    initial begin
        int sig, line, ns, np, lowc;
        int pat [4] = '{1, 2, 3, -3};
        for (int i = 0; i < DEPTH; i++) begin m_str[i] = 0; m_conf[i] = 0; end

        repeat (3) @(negedge clk);
        chk(pf_valid == 1'b0 && sig_valid == 1'b0 && ready == 1'b0, "R1",
            int'({pf_valid, sig_valid, ready}), 0);
        rst_n = 1'b1;
        lowc = 0;
        for (int i = 0; i < DEPTH + 10; i++) begin
            @(negedge clk);
            if (ready) break;
            if (pf_valid || sig_valid) chk(1'b0, "R1", 1, 0);
            lowc++;
        end
        chk(lowc == DEPTH - 1, "R1", lowc, DEPTH - 1);

        // repeating complex pattern
        sig = 0; line = 64 * 200 + 8;
        for (int k = 0; k < 24; k++) begin
            do_req(sig, line, pat[k % 4], (k == 5 || k == 14), "R6", ns, np);
            sig = ns; line = line + pat[k % 4];
        end
        chk(np == 3, "R4", np, 3);

        // stride change: decrement and replacement
        line = 64 * 250 + 2;
        for (int k = 0; k < 16; k++) begin
            do_req(sig, line, 5, 1'b0, "R5", ns, np);
            sig = ns; line = line + 5;
            if (((line >> 6) != ((line + 20) >> 6))) line = 64 * 250 + 2;
        end
        chk(np == 3, "R5", np, 3);

        // ascending walk into page end
        line = 64 * 300 + 40;
        for (int k = 0; k < 30; k++) begin
            do_req(sig, line, 1, 1'b0, "R8", ns, np);
            sig = ns; line = line + 1;
        end

        // descending walk into page start
        line = 64 * 400 + 30;
        for (int k = 0; k < 20; k++) begin
            do_req(sig, line, -2, 1'b0, "R8", ns, np);
            sig = ns; line = line - 2;
        end

        // untouched history: nothing predicted
        do_req(12'h5A3, 64 * 500 + 10, 17, 1'b0, "R7", ns, np);
        chk(np == 0, "R7", np, 0);

        repeat (4) begin
            @(negedge clk);
            chk(pf_valid == 1'b0 && ready == 1'b1, "R2", int'({pf_valid, ready}), 1);
        end
        end_test;
    end
endmodule